// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block maps virtual addresses to physical addresses through a 48-entry table in which any entry may hold any page. Each entry keeps a virtual page tag, a 7-bit address-space identifier, a 2-bit page-size code, a global flag, a physical frame number and a valid bit. A lookup presented in one cycle gives a registered hit flag and physical address in the next cycle. A miss is reported for the surrounding logic to handle. That logic then writes the missing mapping through the fill port.

The fill port picks its own slot. While a free slot exists it takes the free slot with the lowest index. When the table is full, a rotating pointer chooses the slot and steps over the most recently used entry. Two maintenance commands clear the table: one clears all entries, and one clears the entries of one address space.

Top module: `asid_xlate_buffer`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `lk_valid` high. `rsp_hit`, `rsp_multi` and `rsp_pa` describe that earlier request and reflect the table contents from before that clock edge.
- R2: An entry matches when it is valid, its identifier equals `lk_asid` or its global flag is set, and its tag equals the virtual address above the page offset. The size code sets the offset width as 13 + 3*code bits: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB.
- R3: On a hit, `rsp_pa` takes the frame bits above the page offset from the entry and the offset bits from the virtual address. On a miss, `rsp_pa` is zero.
- R4: A single-entry hit makes that entry the most recently used. A fill makes the filled entry the most recently used, and it takes precedence over a hit in the same cycle.
- R5: A lookup that matches two or more entries sets `rsp_multi`, clears `rsp_hit`, returns zero for `rsp_pa`, and leaves the most recently used entry unchanged.
- R6: While any entry is invalid, a fill writes the invalid entry with the lowest index. No valid entry is replaced while an invalid entry exists.
- R7: When every entry is valid, a fill replaces the entry at a rotating pointer, or the next entry if the pointer sits on the most recently used one. After the replacement, the pointer moves to the entry after the one replaced.
- R8: `inv_all` clears every entry. It takes priority over `inv_asid_en` and over a fill in the same cycle, and that fill is discarded.
- R9: `inv_asid_en` clears every non-global entry whose identifier equals `inv_asid`. Global entries and other identifiers are kept. A fill in the same cycle is discarded.
- R10: After reset, every entry is invalid and `rsp_valid`, `rsp_hit` and `rsp_multi` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_multi | output | 1 | Two or more entries matched |
| rsp_pa | output | PA_W | Translated physical address |
| fill_en | input | 1 | Write a new entry |
| fill_va | input | VA_W | Virtual address of the new page |
| fill_asid | input | ASID_W | Identifier of the new page |
| fill_size | input | 2 | Page-size code of the new page |
| fill_global | input | 1 | New page matches any identifier |
| fill_pfn | input | PA_W-13 | Physical frame number, in 8 KB units |
| inv_all | input | 1 | Clear all entries |
| inv_asid_en | input | 1 | Clear the entries of one identifier |
| inv_asid | input | ASID_W | Identifier to clear |

## Verification
The lookup is tried with each of the four page sizes. For each size, one address sits just inside the page and one sits just past its end, which shows whether the correct tag bits are compared and the correct offset bits are passed through. A wrong identifier, a global page and a deliberately duplicated mapping separate identifier filtering from the global override and from multi-match reporting. The replacement test fills the table completely, then turns chosen entries into the most recently used one before each further fill. Which old pages still hit afterwards shows the order in which free slots are used, the rotation of the pointer, and the protection of the most recently used entry.

// File: rtl/axb_pkg.sv
// Package: shared types for the address-space-tagged translation buffer.
// Assumes page sizes grow by a fixed power-of-two step from the base size.
package axb_pkg;
    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    localparam int NUM_SIZES = 4;
endpackage

// File: rtl/axb_tag_cmp.sv
// Module: compares one table entry against a lookup request.
// Assumes the tag is held in base-page units, so the bits below the entry's
// page size are ignored in the comparison.
module axb_tag_cmp #(
    parameter int VPN_W     = 19,
    parameter int ASID_W    = 7,
    parameter int SIZE_STEP = 3
) (
    input  logic              ent_valid,
    input  logic              ent_glob,
    input  logic [1:0]        ent_size,
    input  logic [VPN_W-1:0]  ent_tag,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic              match
);
    logic [VPN_W-1:0] keep_mask;

    // Build the mask of the tag bits that count for this page size.
    always_comb begin
        keep_mask = ~((VPN_W'(1) << (SIZE_STEP * int'(ent_size))) - VPN_W'(1));
        match     = ent_valid
                    && (ent_glob || (ent_asid == req_asid))
                    && (((ent_tag ^ req_vpn) & keep_mask) == '0);
    end
endmodule

// File: rtl/axb_hit_encode.sv
// Module: turns the per-entry match vector into hit, multi-match and index.
// Assumes the index is only meaningful when exactly one bit is set.
module axb_hit_encode #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any_hit,
    output logic               multi_hit,
    output logic [IDX_W-1:0]   hit_idx
);
    // Scan the vector and flag a second match.
    always_comb begin
        any_hit   = 1'b0;
        multi_hit = 1'b0;
        hit_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                if (any_hit) multi_hit = 1'b1;
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/axb_victim_sel.sv
// Module: picks the entry that the next fill writes.
// Assumes ENTRIES >= 2 and that the pointer and the MRU index are below ENTRIES.
module axb_victim_sel #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [IDX_W-1:0]   mru_idx,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic               all_valid,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] first_free;
    logic [IDX_W-1:0] rr_pick;

    // Find the lowest-numbered free entry.
    always_comb begin
        first_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) first_free = IDX_W'(i);
        end
    end

    // Step the rotating choice past the most recently used entry.
    always_comb begin
        if (rr_ptr == mru_idx) rr_pick = (rr_ptr == LAST) ? '0 : rr_ptr + IDX_W'(1);
        else                   rr_pick = rr_ptr;
    end

    // Prefer a free entry, else the rotating choice.
    always_comb begin
        all_valid  = &valid_vec;
        victim_idx = all_valid ? rr_pick : first_free;
    end
endmodule

// File: rtl/asid_xlate_buffer.sv
// Module: translation buffer with any-slot placement, address-space tags,
// per-entry page size and replacement that never picks the MRU entry.
// Assumes PA_W and VA_W cover the largest page offset. Results are registered,
// one cycle after the request.
module asid_xlate_buffer #(
    parameter int ENTRIES    = 48,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int ASID_W     = 7,
    parameter int BASE_SHIFT = 13,
    parameter int SIZE_STEP  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_va,
    input  logic [ASID_W-1:0]        lk_asid,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_multi,
    output logic [PA_W-1:0]          rsp_pa,
    input  logic                     fill_en,
    input  logic [VA_W-1:0]          fill_va,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic [1:0]               fill_size,
    input  logic                     fill_global,
    input  logic [PA_W-BASE_SHIFT-1:0] fill_pfn,
    input  logic                     inv_all,
    input  logic                     inv_asid_en,
    input  logic [ASID_W-1:0]        inv_asid
);
    import axb_pkg::*;

    localparam int VPN_W   = VA_W - BASE_SHIFT;
    localparam int PFN_W   = PA_W - BASE_SHIFT;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int OFF_MAX = BASE_SHIFT + SIZE_STEP * (NUM_SIZES - 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] glob_q;
    logic [1:0]         size_q [ENTRIES];
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];

    logic [IDX_W-1:0]   mru_q;
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match_vec;
    logic               any_hit;
    logic               multi_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic               all_valid;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_go;
    logic               single_hit;
    logic [VPN_W-1:0]   req_vpn;
    logic [PA_W-1:0]    merged_pa;

    assign req_vpn    = lk_va[VA_W-1:BASE_SHIFT];
    assign fill_go    = fill_en && !inv_all && !inv_asid_en;
    assign single_hit = lk_valid && any_hit && !multi_hit;

    // One comparator for each entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        axb_tag_cmp #(
            .VPN_W(VPN_W), .ASID_W(ASID_W), .SIZE_STEP(SIZE_STEP)
        ) u_cmp (
            .ent_valid(valid_q[g]),
            .ent_glob (glob_q[g]),
            .ent_size (size_q[g]),
            .ent_tag  (tag_q[g]),
            .ent_asid (asid_q[g]),
            .req_vpn  (req_vpn),
            .req_asid (lk_asid),
            .match    (match_vec[g])
        );
    end

    axb_hit_encode #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .match_vec(match_vec),
        .any_hit  (any_hit),
        .multi_hit(multi_hit),
        .hit_idx  (hit_idx)
    );

    axb_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_vic (
        .valid_vec (valid_q),
        .mru_idx   (mru_q),
        .rr_ptr    (rr_q),
        .all_valid (all_valid),
        .victim_idx(victim_idx)
    );

    // Join the frame bits of the matching entry with the page offset.
    always_comb begin
        logic [PA_W-1:0] low_mask;
        int unsigned     off_w;
        off_w     = BASE_SHIFT + SIZE_STEP * int'(size_q[hit_idx]);
        low_mask  = (PA_W'(1) << off_w) - PA_W'(1);
        merged_pa = ({pfn_q[hit_idx], {BASE_SHIFT{1'b0}}} & ~low_mask)
                  | (PA_W'(lk_va[OFF_MAX-1:0]) & low_mask);
    end

    // Register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= single_hit;
            rsp_multi <= lk_valid && multi_hit;
            rsp_pa    <= single_hit ? merged_pa : '0;
        end
    end

    // Track the most recently used entry; a fill takes precedence over a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)          mru_q <= '0;
        else if (fill_go)    mru_q <= victim_idx;
        else if (single_hit) mru_q <= hit_idx;
    end

    // Move the rotating pointer past each entry that is replaced.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rr_q <= '0;
        else if (fill_go && all_valid) rr_q <= (victim_idx == LAST) ? '0 : victim_idx + IDX_W'(1);
    end

    // Valid bits: clear all, clear by identifier, or set on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (inv_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!glob_q[i] && (asid_q[i] == inv_asid)) valid_q[i] <= 1'b0;
            end
        end else if (fill_go) begin
            valid_q[victim_idx] <= 1'b1;
        end
    end

    // Entry payload, written by an accepted fill.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            glob_q[victim_idx] <= fill_global;
            size_q[victim_idx] <= fill_size;
            tag_q[victim_idx]  <= fill_va[VA_W-1:BASE_SHIFT];
            asid_q[victim_idx] <= fill_asid;
            pfn_q[victim_idx]  <= fill_pfn;
        end
    end
endmodule

// File: rtl/asid_xlate_buffer_chk.sv
// Module: property checker for the translation buffer, attached with bind.
// Assumes it sees the top's ports and its replacement state.
module asid_xlate_buffer_chk #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_multi,
    input logic               inv_all,
    input logic               fill_go,
    input logic               all_valid,
    input logic [ENTRIES-1:0] valid_q,
    input logic [IDX_W-1:0]   victim_idx,
    input logic [IDX_W-1:0]   mru_q
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r5_multi_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> !rsp_hit);

    a_r6_free_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !all_valid) |-> !valid_q[victim_idx]);

    a_r7_spare_mru: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && all_valid) |-> (victim_idx != mru_q));

    a_r4_fill_becomes_mru: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> (mru_q == $past(victim_idx)));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));
endmodule

bind asid_xlate_buffer asid_xlate_buffer_chk #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_multi (rsp_multi),
    .inv_all   (inv_all),
    .fill_go   (fill_go),
    .all_valid (all_valid),
    .valid_q   (valid_q),
    .victim_idx(victim_idx),
    .mru_q     (mru_q)
);

// File: tb/asid_xlate_buffer_tb.sv
// Bench: directed scenarios for the translation buffer, one task for each.
module asid_xlate_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int PFN_W = PA_W - 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VA_W-1:0]  lk_va = '0;
    logic [6:0]       lk_asid = '0;
    logic             rsp_valid, rsp_hit, rsp_multi;
    logic [PA_W-1:0]  rsp_pa;
    logic             fill_en = 1'b0;
    logic [VA_W-1:0]  fill_va = '0;
    logic [6:0]       fill_asid = '0;
    logic [1:0]       fill_size = '0;
    logic             fill_global = 1'b0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic             inv_all = 1'b0;
    logic             inv_asid_en = 1'b0;
    logic [6:0]       inv_asid = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asid_xlate_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_pa(rsp_pa),
        .fill_en(fill_en), .fill_va(fill_va), .fill_asid(fill_asid), .fill_size(fill_size),
        .fill_global(fill_global), .fill_pfn(fill_pfn),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
    );

    function automatic logic [PA_W-1:0] exp_pa(input logic [PFN_W-1:0] pfn,
                                                input logic [VA_W-1:0] va,
                                                input int sz);
        logic [PA_W-1:0] m;
        m = (PA_W'(1) << (13 + 3 * sz)) - 1;
        return ({pfn, 13'b0} & ~m) | (va & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [VA_W-1:0] va, input logic [6:0] asid,
                        input int sz, input bit glob, input logic [PFN_W-1:0] pfn);
        @(negedge clk);
        fill_en = 1'b1; fill_va = va; fill_asid = asid;
        fill_size = 2'(sz); fill_global = glob; fill_pfn = pfn;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, input logic [6:0] asid,
                          output logic hit, output logic multi, output logic [PA_W-1:0] pa);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
        @(posedge clk); #1;
        hit = rsp_hit; multi = rsp_multi; pa = rsp_pa;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [VA_W-1:0] va, input logic [6:0] asid,
                              input logic [PA_W-1:0] pa_exp);
        logic h, m; logic [PA_W-1:0] p;
        lookup(va, asid, h, m, p);
        check(req, 32'(h), 32'd1);
        check(req, p, pa_exp);
    endtask

    task automatic expect_miss(input string req, input logic [VA_W-1:0] va, input logic [6:0] asid);
        logic h, m; logic [PA_W-1:0] p;
        lookup(va, asid, h, m, p);
        check(req, 32'(h), 32'd0);
        check(req, p, 32'd0);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R10 rsp_hit", 32'(rsp_hit), 32'd0);
        check("R10 rsp_multi", 32'(rsp_multi), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        expect_miss("R10 empty after reset", 32'h1234_6000, 7'd5);
    endtask

    task automatic t_timing();
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 32'h0; lk_asid = 7'd0;
        @(posedge clk); #1;
        check("R1 rsp_valid next cycle", 32'(rsp_valid), 32'd1);
        @(negedge clk); lk_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 rsp_valid drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_sizes();
        fill(32'h1234_6000, 7'd5, 0, 1'b0, 19'h00ABC);
        expect_hit("R2 R3 8K hit", 32'h1234_6ABC, 7'd5, exp_pa(19'h00ABC, 32'h1234_6ABC, 0));
        expect_miss("R2 8K next page", 32'h1234_8000, 7'd5);
        expect_miss("R2 wrong asid", 32'h1234_6ABC, 7'd6);
        fill(32'h2001_0000, 7'd5, 1, 1'b0, 19'h01237);
        expect_hit("R2 R3 64K hit", 32'h2001_FFFC, 7'd5, exp_pa(19'h01237, 32'h2001_FFFC, 1));
        expect_miss("R2 64K past end", 32'h2002_0000, 7'd5);
        fill(32'h3008_0000, 7'd5, 2, 1'b0, 19'h0F0F3);
        expect_hit("R2 R3 512K hit", 32'h300F_FFF0, 7'd5, exp_pa(19'h0F0F3, 32'h300F_FFF0, 2));
        expect_miss("R2 512K past end", 32'h3010_0000, 7'd5);
        fill(32'h4000_0000, 7'd5, 3, 1'b0, 19'h12345);
        expect_hit("R2 R3 4M hit", 32'h403F_FFF0, 7'd5, exp_pa(19'h12345, 32'h403F_FFF0, 3));
        expect_miss("R2 4M past end", 32'h4040_0000, 7'd5);
    endtask

    task automatic t_global();
        fill(32'h5000_0000, 7'd9, 0, 1'b1, 19'h00055);
        expect_hit("R2 global any asid", 32'h5000_0010, 7'd3, exp_pa(19'h00055, 32'h5000_0010, 0));
        fill(32'h6000_0000, 7'd7, 0, 1'b0, 19'h00066);
        expect_hit("R2 asid7 page", 32'h6000_0020, 7'd7, exp_pa(19'h00066, 32'h6000_0020, 0));
    endtask

    task automatic t_multi();
        logic h, m; logic [PA_W-1:0] p;
        fill(32'h7000_0000, 7'd2, 0, 1'b0, 19'h00070);
        fill(32'h7000_0000, 7'd2, 0, 1'b0, 19'h00071);
        lookup(32'h7000_0004, 7'd2, h, m, p);
        check("R5 multi flag", 32'(m), 32'd1);
        check("R5 multi not hit", 32'(h), 32'd0);
        check("R5 multi pa zero", p, 32'd0);
    endtask

    task automatic t_inv_asid();
        @(negedge clk);
        inv_asid_en = 1'b1; inv_asid = 7'd5;
        fill_en = 1'b1; fill_va = 32'h0900_0000; fill_asid = 7'd3;
        fill_size = 2'd0; fill_global = 1'b0; fill_pfn = 19'h00099;
        @(negedge clk);
        inv_asid_en = 1'b0; fill_en = 1'b0;
        expect_miss("R9 asid5 8K cleared", 32'h1234_6ABC, 7'd5);
        expect_miss("R9 asid5 4M cleared", 32'h403F_FFF0, 7'd5);
        expect_hit("R9 global kept", 32'h5000_0010, 7'd5, exp_pa(19'h00055, 32'h5000_0010, 0));
        expect_hit("R9 asid7 kept", 32'h6000_0020, 7'd7, exp_pa(19'h00066, 32'h6000_0020, 0));
        expect_miss("R9 same-cycle fill dropped", 32'h0900_0000, 7'd3);
    endtask

    task automatic t_inv_all();
        @(negedge clk);
        inv_all = 1'b1; inv_asid_en = 1'b1; inv_asid = 7'd1;
        fill_en = 1'b1; fill_va = 32'h0A00_0000; fill_asid = 7'd3;
        fill_size = 2'd0; fill_global = 1'b1; fill_pfn = 19'h000AA;
        @(negedge clk);
        inv_all = 1'b0; inv_asid_en = 1'b0; fill_en = 1'b0;
        expect_miss("R8 global cleared", 32'h5000_0010, 7'd9);
        expect_miss("R8 asid7 cleared", 32'h6000_0020, 7'd7);
        expect_miss("R8 fill dropped", 32'h0A00_0000, 7'd3);
    endtask

    task automatic t_replace();
        logic h, m; logic [PA_W-1:0] p;
        for (int i = 0; i < 48; i++) fill(32'(i) << 13, 7'd1, 0, 1'b0, 19'(i + 'h40));
        for (int i = 0; i < 48; i++)
            expect_hit("R6 all 48 kept", (32'(i) << 13) | 32'h10, 7'd1,
                       exp_pa(19'(i + 'h40), (32'(i) << 13) | 32'h10, 0));
        // Pointer at slot 0, which the next lookup makes MRU: slot 1 goes.
        lookup(32'h0, 7'd1, h, m, p);
        fill(32'h0100_0000, 7'd1, 0, 1'b0, 19'h00100);
        expect_hit("R7 R4 MRU slot 0 spared", 32'h0, 7'd1, exp_pa(19'h40, 32'h0, 0));
        expect_miss("R7 slot 1 replaced", 32'h0000_2000, 7'd1);
        expect_hit("R7 new page present", 32'h0100_0000, 7'd1, exp_pa(19'h00100, 32'h0100_0000, 0));
        // Pointer now at slot 2.
        fill(32'h0200_0000, 7'd1, 0, 1'b0, 19'h00200);
        expect_miss("R7 slot 2 replaced", 32'h0000_4000, 7'd1);
        expect_hit("R7 slot 3 kept", 32'h0000_6000, 7'd1, exp_pa(19'h43, 32'h0000_6000, 0));
        // That lookup made slot 3 MRU and the pointer sits there: slot 4 goes.
        fill(32'h0300_0000, 7'd1, 0, 1'b0, 19'h00300);
        expect_hit("R4 hit-made MRU spared", 32'h0000_6000, 7'd1, exp_pa(19'h43, 32'h0000_6000, 0));
        expect_miss("R7 slot 4 replaced", 32'h0000_8000, 7'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_timing();
        t_sizes();
        t_global();
        t_multi();
        t_inv_asid();
        t_inv_all();
        t_replace();
        finish_run();
    end
endmodule